// File: doc/BRIEF.md
# Strobed Asynchronous Character Retimer

This block sits behind an FSK demodulator that delivers a 1200 baud asynchronous bit stream. It hunts for the falling edge that opens each start bit, confirms the start bit halfway through, then samples the eight data bits at their centres into an internal register. Bit timing comes from the system clock through a divider that produces sixteen oversampling ticks per bit.

A small host controller with no UART reads each character serially. When a character is complete and the host's strobe input is low, the block pulls its active-low interrupt and puts the first data bit on a shared serial output. The host then pulses the strobe; each high-to-low edge moves the next bit onto the output. After the eighth pulse the output carries the raw demodulator stream again. A host that keeps the strobe high disables the retiming: the output then always carries raw data and the interrupt stays inactive.

Top module: `strobe_char_retimer`

## Requirements
- R1: After reset `irq_n` is 1 and `ser_out` follows `rx_raw` through a two-flop synchronizer.
- R2: A 1-to-0 transition on `rx_raw` starts a character; the line is re-sampled OVS/2 ticks later, and if it is high again the character is abandoned with no interrupt.
- R3: One bit lasts OVS ticks of CLK_DIV clocks each; the eight data bits are sampled at their centres and stored with the first received bit as bit 0 (least significant first).
- R4: When the eighth bit is stored and the synchronized strobe is low, `irq_n` goes to 0 and `ser_out` shows data bit 0.
- R5: `irq_n` returns to 1 on the first rising edge of the strobe after it was asserted.
- R6: Each of the first seven strobe falling edges puts the next data bit on `ser_out`; `ser_out` does not change between falling edges; the eighth falling edge returns `ser_out` to raw data.
- R7: If the strobe is high when a character completes, no interrupt is raised and `ser_out` keeps following raw data.
- R8: A character that completes while a read-out is in progress is discarded, and the read-out in progress continues unchanged.
- R9: While `fsk_en` is 0 the receiver and the read-out are held idle: `irq_n` is 1 and `ser_out` carries raw data; lowering `fsk_en` during a read-out aborts it.
- R10: A continuous alternating mark/space stream is read out as characters of value 0x55.
- R11: `ser_out` responds to a strobe edge within four clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fsk_en | input | 1 | Enables character capture and read-out |
| rx_raw | input | 1 | Demodulated serial data, 1 = mark |
| strobe_in | input | 1 | Host read strobe, asynchronous |
| irq_n | output | 1 | Active-low character-ready interrupt |
| ser_out | output | 1 | Raw data, or the stored bit during a read-out |

## Verification
The bench sends a short low glitch on the line: a design that skipped the mid-start re-check would capture a spurious character and pull the interrupt. It sends a second character before the first is read; a design that overwrote the buffer would hand the host the second character's bits partway through. It holds the strobe high across a whole character, where a design ignoring that state would raise an interrupt, and it lowers the enable mid-read-out, where a design without the abort would keep driving stored bits. Patterns such as 0xA7, 0x00 and 0x55 expose reversed bit order, a stuck last bit and an off-by-one in the eight-edge count.

// File: rtl/retimer_pkg.sv
package retimer_pkg;

    localparam int CHAR_BITS = 8;
    localparam int IDX_W     = $clog2(CHAR_BITS);

    typedef enum logic [1:0] {
        CAP_IDLE  = 2'd0,
        CAP_START = 2'd1,
        CAP_DATA  = 2'd2
    } cap_state_e;

    typedef struct packed {
        logic                 busy;
        logic                 irq;
        logic [IDX_W-1:0]     idx;
        logic [CHAR_BITS-1:0] bits;
    } rd_state_t;

    function automatic logic is_fall(input logic prev, input logic cur);
        return prev & ~cur;
    endfunction

    function automatic logic is_rise(input logic prev, input logic cur);
        return ~prev & cur;
    endfunction

endpackage

// File: rtl/retimer_sync.sv
module retimer_sync #(
    parameter int               WIDTH   = 2,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= RST_VAL;
        else     stg[0] <= d;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[g] <= RST_VAL;
            else     stg[g] <= stg[g-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/retimer_baud_tick.sv
module retimer_baud_tick #(
    parameter int DIV = 186
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == CW'(DIV - 1)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/retimer_capture.sv
module retimer_capture
    import retimer_pkg::*;
#(
    parameter int CLK_DIV = 186,
    parameter int OVS     = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 rx_s,
    output logic                 done,
    output logic [CHAR_BITS-1:0] data
);
    localparam int TW   = $clog2(OVS);
    localparam int BW   = $clog2(CHAR_BITS);
    localparam int HALF = OVS / 2;

    cap_state_e           state;
    logic [TW-1:0]        tick_cnt;
    logic [BW-1:0]        bit_cnt;
    logic [CHAR_BITS-1:0] shreg;
    logic                 rx_prev;
    logic                 tick;
    logic                 start_det;

    assign start_det = en && (state == CAP_IDLE) && is_fall(rx_prev, rx_s);

    retimer_baud_tick #(.DIV(CLK_DIV)) tick_i (
        .clk  (clk),
        .rst  (rst),
        .clr  (start_det),
        .tick (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= CAP_IDLE;
            tick_cnt <= '0;
            bit_cnt  <= '0;
            shreg    <= '0;
            rx_prev  <= 1'b1;
            done     <= 1'b0;
        end else if (!en) begin
            state    <= CAP_IDLE;
            tick_cnt <= '0;
            bit_cnt  <= '0;
            rx_prev  <= rx_s;
            done     <= 1'b0;
        end else begin
            done    <= 1'b0;
            rx_prev <= rx_s;
            case (state)
                CAP_IDLE: begin
                    if (start_det) begin
                        state    <= CAP_START;
                        tick_cnt <= '0;
                    end
                end
                CAP_START: begin
                    if (tick) begin
                        if (tick_cnt == TW'(HALF - 1)) begin
                            tick_cnt <= '0;
                            bit_cnt  <= '0;
                            state    <= rx_s ? CAP_IDLE : CAP_DATA;
                        end else begin
                            tick_cnt <= tick_cnt + 1'b1;
                        end
                    end
                end
                CAP_DATA: begin
                    if (tick) begin
                        if (tick_cnt == TW'(OVS - 1)) begin
                            tick_cnt <= '0;
                            shreg    <= {rx_s, shreg[CHAR_BITS-1:1]};
                            bit_cnt  <= bit_cnt + 1'b1;
                            if (bit_cnt == BW'(CHAR_BITS - 1)) begin
                                done  <= 1'b1;
                                state <= CAP_IDLE;
                            end
                        end else begin
                            tick_cnt <= tick_cnt + 1'b1;
                        end
                    end
                end
                default: state <= CAP_IDLE;
            endcase
        end
    end

    assign data = shreg;
endmodule

// File: rtl/retimer_readout.sv
module retimer_readout
    import retimer_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 strobe_s,
    input  logic                 raw_s,
    input  logic                 cap_done,
    input  logic [CHAR_BITS-1:0] cap_data,
    output logic                 irq_n,
    output logic                 ser_out,
    output logic                 busy
);
    rd_state_t st, nxt;
    logic      strobe_prev;
    logic      rise, fall;

    assign rise = is_rise(strobe_prev, strobe_s);
    assign fall = is_fall(strobe_prev, strobe_s);

    always_comb begin
        nxt = st;
        if (!st.busy) begin
            if (cap_done && !strobe_s) begin
                nxt.busy = 1'b1;
                nxt.irq  = 1'b1;
                nxt.idx  = '0;
                nxt.bits = cap_data;
            end
        end else begin
            if (rise) nxt.irq = 1'b0;
            if (fall) begin
                if (st.idx == IDX_W'(CHAR_BITS - 1)) begin
                    nxt.busy = 1'b0;
                end else begin
                    nxt.idx  = st.idx + 1'b1;
                    nxt.bits = {1'b0, st.bits[CHAR_BITS-1:1]};
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en) st <= '0;
        else            st <= nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) strobe_prev <= 1'b1;
        else     strobe_prev <= strobe_s;
    end

    assign irq_n   = ~st.irq;
    assign busy    = st.busy;
    assign ser_out = st.busy ? st.bits[0] : raw_s;
endmodule

// File: rtl/strobe_char_retimer.sv
module strobe_char_retimer
    import retimer_pkg::*;
#(
    parameter int CLK_DIV     = 186,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic fsk_en,
    input  logic rx_raw,
    input  logic strobe_in,
    output logic irq_n,
    output logic ser_out
);
    logic [1:0]           sync_q;
    logic                 strobe_s;
    logic                 raw_s;
    logic                 cap_done;
    logic [CHAR_BITS-1:0] cap_data;
    logic                 rd_busy;

    retimer_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   ({strobe_in, rx_raw}),
        .q   (sync_q)
    );

    assign strobe_s = sync_q[1];
    assign raw_s    = sync_q[0];

    retimer_capture #(.CLK_DIV(CLK_DIV), .OVS(OVS)) cap_i (
        .clk  (clk),
        .rst  (rst),
        .en   (fsk_en),
        .rx_s (raw_s),
        .done (cap_done),
        .data (cap_data)
    );

    retimer_readout rd_i (
        .clk      (clk),
        .rst      (rst),
        .en       (fsk_en),
        .strobe_s (strobe_s),
        .raw_s    (raw_s),
        .cap_done (cap_done),
        .cap_data (cap_data),
        .irq_n    (irq_n),
        .ser_out  (ser_out),
        .busy     (rd_busy)
    );
endmodule

// File: rtl/retimer_checker.sv
module retimer_checker (
    input logic clk,
    input logic rst,
    input logic fsk_en,
    input logic irq_n,
    input logic ser_out,
    input logic strobe_s,
    input logic rd_busy
);
    logic prev_c;
    logic fall_c;

    always_ff @(posedge clk) begin
        if (rst) prev_c <= 1'b1;
        else     prev_c <= strobe_s;
    end

    assign fall_c = prev_c && !strobe_s;

    // R9: disabled receiver never holds the interrupt
    assert_irq_off_disabled_R9: assert property (@(posedge clk) disable iff (rst)
        !fsk_en |=> irq_n);

    // R4, R7: interrupt only asserts when the strobe was low
    assert_irq_needs_low_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_n) |-> !$past(strobe_s));

    // R5: first strobe rise clears the interrupt
    assert_irq_release_R5: assert property (@(posedge clk) disable iff (rst)
        (!irq_n && fsk_en && strobe_s && !prev_c) |=> irq_n);

    // R6: output frozen between strobe falling edges
    assert_hold_between_falls_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_busy && fsk_en && !fall_c) |=> $stable(ser_out));

    // R8: a read-out is never cut short by a new character
    assert_readout_kept_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_busy && fsk_en && !fall_c) |=> rd_busy);

    // R4: interrupt only while a character is held
    assert_irq_implies_busy_R4: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> rd_busy);
endmodule

bind strobe_char_retimer retimer_checker chk_i (
    .clk      (clk),
    .rst      (rst),
    .fsk_en   (fsk_en),
    .irq_n    (irq_n),
    .ser_out  (ser_out),
    .strobe_s (strobe_s),
    .rd_busy  (rd_busy)
);

// File: tb/strobe_char_retimer_tb.sv
module strobe_char_retimer_tb_top;
    localparam int DIV = 4;
    localparam int OVS = 16;
    localparam int BIT = DIV * OVS;
    localparam int WD  = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fsk_en = 1'b1;
    logic rx_raw = 1'b1;
    logic strobe_in = 1'b0;
    logic irq_n;
    logic ser_out;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    strobe_char_retimer #(.CLK_DIV(DIV), .OVS(OVS), .SYNC_STAGES(2)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .fsk_en    (fsk_en),
        .rx_raw    (rx_raw),
        .strobe_in (strobe_in),
        .irq_n     (irq_n),
        .ser_out   (ser_out)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        rx_raw = b;
        cyc(BIT);
    endtask

    task automatic send_char(input logic [7:0] d);
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(d[i]);
        send_bit(1'b1);
    endtask

    // R6, R11: strobe out eight bits, check each and the return to raw
    task automatic read_char(input logic [7:0] exp, input string tag);
        for (int i = 0; i < 8; i++) begin
            chk({tag, " R6 bit"}, int'(ser_out), int'(exp[i]));
            strobe_in = 1'b1;
            cyc(4);
            if (i == 0) chk("R5 irq released on first strobe rise", int'(irq_n), 1);
            chk("R6 output stable while strobe high", int'(ser_out), int'(exp[i]));
            cyc(2);
            strobe_in = 1'b0;
            cyc(4);
        end
        rx_raw = 1'b0;
        cyc(4);
        chk("R6 raw data after eighth strobe", int'(ser_out), 0);
        rx_raw = 1'b1;
        cyc(4);
        chk("R6 raw data after eighth strobe", int'(ser_out), 1);
        cyc(BIT);
    endtask

    task automatic t_reset_and_glitch;
        chk("R1 irq_n after reset", int'(irq_n), 1);
        chk("R1 ser_out follows idle line", int'(ser_out), 1);
        rx_raw = 1'b0;
        cyc(4);
        chk("R1 ser_out follows raw low", int'(ser_out), 0);
        rx_raw = 1'b1;
        cyc(12 * BIT);
        chk("R2 short glitch raises no interrupt", int'(irq_n), 1);
    endtask

    task automatic t_basic(input logic [7:0] d);
        strobe_in = 1'b0;
        send_char(d);
        chk("R4 irq asserted after character", int'(irq_n), 0);
        chk("R4 first bit presented", int'(ser_out), int'(d[0]));
        read_char(d, "R3 lsb-first capture");
        chk("R5 irq idle after read-out", int'(irq_n), 1);
    endtask

    task automatic t_seizure;
        // R10: two alternating-pattern characters back to back
        strobe_in = 1'b0;
        for (int c = 0; c < 2; c++) begin
            send_char(8'h55);
            chk("R10 irq for seizure char", int'(irq_n), 0);
            read_char(8'h55, "R10 seizure 0x55");
        end
    endtask

    task automatic t_no_retime;
        logic [7:0] d;
        d = 8'h3C;
        strobe_in = 1'b1;
        cyc(6);
        for (int i = 0; i < 10; i++) begin
            rx_raw = (i == 0) ? 1'b0 : (i == 9) ? 1'b1 : d[i-1];
            cyc(BIT / 2);
            chk("R7 raw passthrough with strobe high", int'(ser_out), int'(rx_raw));
            chk("R7 no irq with strobe high", int'(irq_n), 1);
            cyc(BIT - BIT / 2);
        end
        cyc(BIT);
        chk("R7 no irq after character", int'(irq_n), 1);
        strobe_in = 1'b0;
        cyc(6);
    endtask

    task automatic t_overrun;
        strobe_in = 1'b0;
        send_char(8'h12);
        send_char(8'h34);
        chk("R8 irq still held for first char", int'(irq_n), 0);
        read_char(8'h12, "R8 first character kept");
        chk("R8 second character dropped", int'(irq_n), 1);
    endtask

    task automatic t_disable;
        strobe_in = 1'b0;
        fsk_en = 1'b0;
        send_char(8'h5A);
        chk("R9 no irq while disabled", int'(irq_n), 1);
        rx_raw = 1'b0;
        cyc(4);
        chk("R9 raw output while disabled", int'(ser_out), 0);
        rx_raw = 1'b1;
        fsk_en = 1'b1;
        cyc(BIT);
        send_char(8'h81);
        chk("R9 irq before abort", int'(irq_n), 0);
        fsk_en = 1'b0;
        cyc(3);
        chk("R9 abort clears irq", int'(irq_n), 1);
        chk("R9 abort returns raw output", int'(ser_out), 1);
        fsk_en = 1'b1;
        cyc(BIT);
        chk("R9 stays idle after re-enable", int'(irq_n), 1);
    endtask

    initial begin
        cyc(5);
        rst = 1'b0;
        cyc(5);
        t_reset_and_glitch();
        t_basic(8'hA7);
        t_basic(8'h00);
        t_basic(8'hFF);
        t_seizure();
        t_no_retime();
        t_overrun();
        t_disable();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (WD) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule